// File: doc/BRIEF.md
# Reference Prescaler with Shared Rate Tap

This block turns a 32.768 kHz reference into the timing events that a real-time clock needs. The reference arrives as a one-cycle enable pulse, `ref_tick`, in the fast system clock domain. Each pulse advances a 15-bit binary divider chain, built as three cascaded stages of 3, 6 and 6 bits. The last stage carries out once per second.

A 4-bit rate code picks one chain bit through a single 16-way selector. That one selected tap drives two outputs. The first is a one-cycle periodic event, raised on each rising edge of the tap. The second is a square-wave pin, which is gated by an enable input and forced low while a power-fail input is high. Each carry out of the whole chain raises a one-cycle 1 Hz strobe for the calendar logic.

A hold input clears the chain and keeps it at zero for as long as it stays high. Every port carries a plain level or a pulse. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `presc_top`

## Requirements
- R1: While `rst_n` is low, `sqw_out`, `periodic_evt` and `sec_strobe` are 0, and the chain is zero once reset is released.
- R2: Each cycle with `ref_tick` high and `div_hold` low adds one to the 15-bit chain, modulo 32768. Cycles without `ref_tick` leave the chain unchanged.
- R3: Rate codes 3 to 15 select chain bit (code − 2), which gives 32768/2^(code−1) Hz: code 3 is 8192 Hz and code 15 is 2 Hz. Code 1 selects bit 6 (256 Hz) and code 2 selects bit 7 (128 Hz).
- R4: Rate code 0 selects a constant 0. With code 0, both `periodic_evt` and `sqw_out` stay low.
- R5: With `sqw_en` low, `sqw_out` is 0.
- R6: With `pwr_fail` high, `sqw_out` is 0, whatever `sqw_en` and the tap are.
- R7: `periodic_evt` is high for exactly one cycle for each 0→1 change of the selected tap. It is never high in two consecutive cycles.
- R8: `sec_strobe` is high for one cycle after a `ref_tick` that moves the chain from 32767 to 0.
- R9: While `div_hold` is high, the chain is cleared and held at zero, and no `sec_strobe` is produced.
- R10: Every output is registered. It reflects the chain value, `rate_sel`, `sqw_en` and `pwr_fail` as they stand at the clock edge that updates the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| div_hold | input | 1 | Clears the chain and holds it at zero while high |
| rate_sel | input | 4 | Rate code for the shared tap selector |
| sqw_en | input | 1 | Enables the square-wave output |
| pwr_fail | input | 1 | Supply below threshold; forces the square wave low |
| sqw_out | output | 1 | Gated square wave from the selected tap |
| periodic_evt | output | 1 | One-cycle pulse on each rising edge of the selected tap |
| sec_strobe | output | 1 | One-cycle pulse once per chain wrap (1 Hz) |

## Verification
A `ref_tick` sampled at clock edge k changes the chain at edge k. The effect of that change on `sqw_out`, `periodic_evt` and `sec_strobe` appears at edge k+1. A change of `rate_sel`, `sqw_en` or `pwr_fail` shows on the outputs at the first edge that samples it. So each output is due exactly one register after its cause.

The bench drives new inputs and compares outputs at the falling edge. After each drive it predicts what the next rising edge will produce, using its own tick count and the tap rule in R3. It then checks that prediction at the following falling edge. This keeps every comparison exactly one cycle after its cause.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int RATE_W = 4;

  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    logic       live;
    logic [3:0] bit_idx;
  } tap_pick_t;

  // Rate code to chain bit: 0 = off, 1 -> 256 Hz, 2 -> 128 Hz, c>=3 -> bit c-2
  function automatic tap_pick_t pick_tap(input rate_t code);
    tap_pick_t p;
    p.live    = 1'b1;
    p.bit_idx = 4'd0;
    case (code)
      4'd0:    p.live = 1'b0;
      4'd1:    p.bit_idx = 4'd6;
      4'd2:    p.bit_idx = 4'd7;
      default: p.bit_idx = 4'(code - 4'd2);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/presc_stage.sv
module presc_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         carry
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign carry = inc & (&cnt);

  a_r9_stage_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  a_r2_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/presc_tap_sel.sv
module presc_tap_sel
  import presc_pkg::*;
#(
  parameter int CHAIN_W = 15
) (
  input  logic [CHAIN_W-1:0] chain,
  input  rate_t              rate_sel,
  output logic               tap
);
  tap_pick_t pick;

  always_comb begin
    pick = pick_tap(rate_sel);
    tap  = 1'b0;
    for (int i = 0; i < CHAIN_W; i++) begin
      if (pick.live && (32'(pick.bit_idx) == i)) tap = chain[i];
    end
  end
endmodule

// File: rtl/presc_out.sv
module presc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic sqw_en,
  input  logic pwr_fail,
  input  logic wrap,
  input  logic div_hold,
  output logic sqw_out,
  output logic periodic_evt,
  output logic sec_strobe
);
  logic tap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_d        <= 1'b0;
      sqw_out      <= 1'b0;
      periodic_evt <= 1'b0;
      sec_strobe   <= 1'b0;
    end else begin
      tap_d        <= tap;
      sqw_out      <= tap & sqw_en & ~pwr_fail;
      periodic_evt <= tap & ~tap_d;
      sec_strobe   <= wrap & ~div_hold;
    end
  end

  a_r6_pf_blocks_sqw: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sqw_out);
  a_r5_en_gates_sqw: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |=> !sqw_out);
  a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |=> !periodic_evt);
  a_r8_strobe_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> $past(wrap));
endmodule

// File: rtl/presc_top.sv
module presc_top
  import presc_pkg::*;
#(
  parameter int S0_W = 3,
  parameter int S1_W = 6,
  parameter int S2_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       div_hold,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       pwr_fail,
  output logic       sqw_out,
  output logic       periodic_evt,
  output logic       sec_strobe
);
  localparam int N_STG   = 3;
  localparam int CHAIN_W = S0_W + S1_W + S2_W;

  function automatic int stg_w(input int g);
    return (g == 0) ? S0_W : (g == 1) ? S1_W : S2_W;
  endfunction

  function automatic int stg_lsb(input int g);
    int s = 0;
    for (int k = 0; k < g; k++) s += stg_w(k);
    return s;
  endfunction

  logic [CHAIN_W-1:0] chain;
  logic [N_STG:0]     inc;
  logic               tap;

  assign inc[0] = ref_tick;

  for (genvar g = 0; g < N_STG; g++) begin : g_stage
    localparam int W = stg_w(g);
    localparam int L = stg_lsb(g);
    presc_stage #(.W(W)) stage_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (div_hold),
      .inc  (inc[g]),
      .cnt  (chain[L+W-1:L]),
      .carry(inc[g+1])
    );
  end

  presc_tap_sel #(.CHAIN_W(CHAIN_W)) tap_i (
    .chain   (chain),
    .rate_sel(rate_sel),
    .tap     (tap)
  );

  presc_out out_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap         (tap),
    .sqw_en      (sqw_en),
    .pwr_fail    (pwr_fail),
    .wrap        (inc[N_STG]),
    .div_hold    (div_hold),
    .sqw_out     (sqw_out),
    .periodic_evt(periodic_evt),
    .sec_strobe  (sec_strobe)
  );

  a_r4_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> (!periodic_evt && !sqw_out));
  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> !sec_strobe);
  a_r8_wrap_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && !$past(div_hold)) |-> ($past(chain) == '1));
  a_r9_hold_zero_chain: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> (chain == '0));
endmodule

// File: tb/presc_tb_top.sv
`timescale 1ns/1ps
module presc_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, ref_tick, div_hold, sqw_en, pwr_fail;
  logic [3:0] rate_sel;
  logic       sqw_out, periodic_evt, sec_strobe;

  presc_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_hold(div_hold),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .pwr_fail(pwr_fail),
    .sqw_out(sqw_out), .periodic_evt(periodic_evt), .sec_strobe(sec_strobe)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [14:0] m_cnt;
  logic        m_tapd;
  logic        e_sqw, e_evt, e_sec;
  string       t_sqw, t_evt, t_sec;

  // R3/R4 tap rule from the requirement text
  function automatic logic want_tap(input logic [14:0] c, input logic [3:0] r);
    if (r == 4'd0) return 1'b0;
    if (r == 4'd1) return c[6];
    if (r == 4'd2) return c[7];
    return c[r - 4'd2];
  endfunction

  task automatic check(input string tag, input string nm, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(input logic rt, input logic hd, input logic [3:0] rs,
                      input logic en, input logic pf);
    logic tp;
    @(negedge clk);
    check(t_sqw, "sqw_out", sqw_out, e_sqw);
    check(t_evt, "periodic_evt", periodic_evt, e_evt);
    check(t_sec, "sec_strobe", sec_strobe, e_sec);
    ref_tick = rt; div_hold = hd; rate_sel = rs; sqw_en = en; pwr_fail = pf;
    tp     = want_tap(m_cnt, rs);
    e_sqw  = tp & en & ~pf;
    e_evt  = tp & ~m_tapd;
    e_sec  = rt & (m_cnt == 15'h7FFF) & ~hd;
    m_tapd = tp;
    t_sqw  = pf ? "R6" : (!en ? "R5" : (rs == 0 ? "R4" : "R3 R2 R10"));
    t_evt  = (rs == 0) ? "R4 R7" : "R7 R10";
    t_sec  = hd ? "R9" : "R8";
    if (hd) m_cnt = '0;
    else if (rt) m_cnt = m_cnt + 15'd1;
  endtask

  initial begin
    rst_n = 0; ref_tick = 0; div_hold = 0; rate_sel = 0; sqw_en = 0; pwr_fail = 0;
    m_cnt = '0; m_tapd = 0; e_sqw = 0; e_evt = 0; e_sec = 0;
    t_sqw = "R1"; t_evt = "R1"; t_sec = "R1";
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    check("R1", "sqw_out", sqw_out, 1'b0);
    check("R1", "periodic_evt", periodic_evt, 1'b0);
    check("R1", "sec_strobe", sec_strobe, 1'b0);
    rst_n = 1;
    // R3 R4: sweep every rate code with steady ticks
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < 700; k++) step(1'b1, 1'b0, 4'(r), 1'b1, 1'b0);
    // R5 R6 R9: random mix
    for (int k = 0; k < 20000; k++)
      step(1'($urandom % 3 != 0), 1'($urandom % 97 == 0), 4'($urandom % 16),
           1'($urandom % 4 != 0), 1'($urandom % 5 == 0));
    // R9 then R8: clear, then run a full chain wrap and past it
    step(1'b1, 1'b1, 4'd15, 1'b1, 1'b0);
    for (int k = 0; k < 33000; k++) step(1'b1, 1'b0, 4'd15, 1'b1, 1'b0);
    // R9: hold exactly on the wrap tick suppresses the strobe
    while (m_cnt != 15'h7FFF) step(1'b1, 1'b0, 4'd3, 1'b1, 1'b0);
    step(1'b1, 1'b1, 4'd3, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 4'd3, 1'b1, 1'b0);
    step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule